// File: doc/BRIEF.md
# Descriptor Quad Load/Store Engine

The engine runs one single-location register move that a 16-byte command descriptor in memory describes. A start pulse gives it the descriptor address. It then reads the descriptor as four 32-bit little-endian words over a request/acknowledge memory master port. It decodes the command, the key, the size and the target address, and performs one access of 1, 2 or 4 bytes. A store command writes the low bytes of the descriptor's argument word to the target. A load command reads the target and writes the zero-extended value back into the argument word of the same descriptor. The descriptor therefore serves as both the data source and the data sink.

When the command finishes, the engine writes the request count into the descriptor's residual field, pulses `done`, and pulses `irq` if the descriptor asks for an interrupt. Error bits report a wrong key, a misaligned target, a load whose descriptor is read-only, and an unknown opcode. The error bits stay readable until the next command starts. A wake status bit is set from outside and is cleared each time a descriptor fetch begins.

Descriptor layout, all fields little-endian:
- Word 0 (byte 0): bits [15:0] request count, bits [23:16] key byte, bits [27:26] interrupt select, bits [31:28] opcode.
- Word 1 (byte 4): target address.
- Word 2 (byte 8): argument.
- Word 3 (byte 12): bits [15:0] residual count, bits [31:16] transfer status (never written).

Top module: `quad_desc_engine`

## Requirements
- R1: After reset `busy`, `done`, `irq`, `mem_req` and `wake_stat` are 0 and `err` is 4'b0000.
- R2: In idle, `start` is accepted and the descriptor base becomes `start_addr` with bits [3:0] cleared. The engine then reads words at base+0, +4, +8 and +12 in that order, with `mem_be`=4'hF. A `start` while busy is ignored and causes no bus access.
- R3: A `wake_req` pulse sets `wake_stat`. `wake_stat` is cleared when a start is accepted.
- R4: The transfer size is 4 bytes when the request count is 4 and 2 bytes when it is 2. Any other count gives 1 byte.
- R5: If the target is not a multiple of the size, `err[1]` is set, the low address bits are cleared, and the access still happens.
- R6: A store (opcode 4'h4) writes to the aligned target with `mem_be` = 4'hF for size 4, 4'b0011 shifted left by the byte lane for size 2, or 4'b0001 shifted left by the byte lane for size 1. On each enabled lane it drives argument byte 0 (size 1), argument bytes 0/1 (size 2) or the matching argument byte (size 4).
- R7: A load (opcode 4'h5) reads the aligned target with the same byte enables as R6. It then writes the selected bytes, shifted down to bit 0 and zero-extended, to base+8 with `mem_be`=4'hF.
- R8: If key byte bits [2:0] are not 3'b110, `err[0]` is set and the command still executes. The other key bits are ignored.
- R9: After the transfer (and after the R7 write for a load), the request count is written to base+12 with `mem_be`=4'b0011.
- R10: If `mem_rdonly` is high on any of the four fetch acknowledges, both descriptor writes are skipped. For a load this also sets `err[2]`; a store still writes its target.
- R11: Any other opcode sets `err[3]` and performs no target access and no descriptor write.
- R12: `irq` pulses together with `done` exactly when word 0 bits [27:26] are nonzero.
- R13: `done` is a one-cycle pulse, followed by idle. `err` keeps its value while idle until the next accepted start.
- R14: While `mem_req` is high and not acknowledged, `mem_req`, `mem_we`, `mem_addr`, `mem_be` and `mem_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only in idle |
| start_addr | input | AW | Descriptor address (bits [3:0] ignored) |
| wake_req | input | 1 | Sets the wake status bit |
| busy | output | 1 | High from the cycle after start until idle returns |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Interrupt pulse at completion |
| err | output | 4 | {bad opcode, read-only descriptor on load, misaligned, bad key} |
| wake_stat | output | 1 | Wake status bit |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | AW | Byte address (word aligned for descriptor accesses) |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge that completes the request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_rdonly | input | 1 | With a read acknowledge: the location cannot be written |

## Verification
The hardest case to reach from the ports is the read-only descriptor. The engine must then skip both write-backs yet still perform a store's target write, and it must flag only loads. The bench's memory model reports the upper half of its array as read-only and ignores writes there. Descriptors placed there therefore drive `mem_rdonly` on every fetch. The scoreboard holds exactly the accesses the requirements allow, so any extra write-back shows up as an unexpected access. A `start` pulse injected mid-command checks the same way that no new fetch begins.

// File: rtl/quad_desc_pkg.sv
package quad_desc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_DECODE,
      ST_XFER,
      ST_WB_ARG,
      ST_WB_RES,
      ST_DONE
   } qd_state_e;

   // error bit positions
   localparam int ERR_KEY   = 0;
   localparam int ERR_ALIGN = 1;
   localparam int ERR_DPROT = 2;
   localparam int ERR_OP    = 3;
   localparam int ERR_W     = 4;

   // one-hot transfer size encoding
   localparam int SZ_1B = 0;
   localparam int SZ_2B = 1;
   localparam int SZ_4B = 2;

endpackage

// File: rtl/qd_desc_regs.sv
module qd_desc_regs #(
   parameter int DW    = 32,
   parameter int WORDS = 4,
   localparam int IDXW = $clog2(WORDS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cap_en,
   input  logic [IDXW-1:0]       cap_idx,
   input  logic [DW-1:0]         cap_data,
   output logic [WORDS*DW-1:0]   words_o
);

   if (WORDS < 2) begin : g_bad_words
      $error("qd_desc_regs: WORDS must be at least 2");
   end

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic [DW-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q <= '0;
         else if (cap_en && (cap_idx == IDXW'(i)))
            word_q <= cap_data;
      end
      assign words_o[i*DW +: DW] = word_q;
   end

endmodule

// File: rtl/qd_decode.sv
module qd_decode
   import quad_desc_pkg::*;
#(
   parameter int          AW       = 32,
   parameter logic [2:0]  KEY_OK   = 3'd6,
   parameter logic [3:0]  OP_STORE = 4'h4,
   parameter logic [3:0]  OP_LOAD  = 4'h5
) (
   input  logic [31:0]    ctl_word,
   input  logic [31:0]    tgt_word,
   output logic           op_store,
   output logic           op_load,
   output logic           op_bad,
   output logic [2:0]     size_1h,
   output logic [AW-1:0]  tgt_al,
   output logic           misalign,
   output logic           key_bad,
   output logic           irq_en,
   output logic [15:0]    req_cnt
);

   logic [3:0]    opcode;
   logic [2:0]    key;
   logic [AW-1:0] tgt_raw;

   assign opcode  = ctl_word[31:28];
   assign key     = ctl_word[18:16];
   assign req_cnt = ctl_word[15:0];
   assign irq_en  = |ctl_word[27:26];
   assign tgt_raw = tgt_word[AW-1:0];

   logic unused_ctl;
   assign unused_ctl = ^ctl_word[25:19];

   assign op_store = (opcode == OP_STORE);
   assign op_load  = (opcode == OP_LOAD);
   assign op_bad   = !op_store && !op_load;
   assign key_bad  = (key != KEY_OK);

   always_comb begin
      size_1h = '0;
      if (req_cnt == 16'd4)
         size_1h[SZ_4B] = 1'b1;
      else if (req_cnt == 16'd2)
         size_1h[SZ_2B] = 1'b1;
      else
         size_1h[SZ_1B] = 1'b1;
   end

   always_comb begin
      tgt_al   = tgt_raw;
      misalign = 1'b0;
      if (size_1h[SZ_4B]) begin
         misalign    = |tgt_raw[1:0];
         tgt_al[1:0] = 2'b00;
      end else if (size_1h[SZ_2B]) begin
         misalign  = tgt_raw[0];
         tgt_al[0] = 1'b0;
      end
   end

endmodule

// File: rtl/qd_lanes.sv
module qd_lanes
   import quad_desc_pkg::*;
#(
   parameter int DW = 32,
   localparam int NB = DW / 8,
   localparam int LW = $clog2(NB)
) (
   input  logic [2:0]     size_1h,
   input  logic [LW-1:0]  lane,
   input  logic [DW-1:0]  st_val,
   input  logic [DW-1:0]  rd_word,
   output logic [NB-1:0]  be_o,
   output logic [DW-1:0]  wdata_o,
   output logic [DW-1:0]  ld_val
);

   if (NB != 4) begin : g_bad_dw
      $error("qd_lanes: only a 32-bit data path is supported");
   end

   always_comb begin
      if (size_1h[SZ_4B])
         be_o = '1;
      else if (size_1h[SZ_2B])
         be_o = NB'(3) << {lane[LW-1:1], 1'b0};
      else
         be_o = NB'(1) << lane;
   end

   for (genvar i = 0; i < NB; i++) begin : g_lane
      assign wdata_o[8*i +: 8] = size_1h[SZ_4B] ? st_val[8*i +: 8] :
                                 size_1h[SZ_2B] ? st_val[8*(i%2) +: 8] :
                                                  st_val[7:0];
   end

   logic [DW-1:0] shifted;
   assign shifted = rd_word >> {lane, 3'b000};

   always_comb begin
      if (size_1h[SZ_4B])
         ld_val = rd_word;
      else if (size_1h[SZ_2B])
         ld_val = {{(DW-16){1'b0}}, shifted[15:0]};
      else
         ld_val = {{(DW-8){1'b0}}, shifted[7:0]};
   end

endmodule

// File: rtl/quad_desc_engine.sv
module quad_desc_engine
   import quad_desc_pkg::*;
#(
   parameter int          AW       = 32,
   parameter logic [2:0]  KEY_OK   = 3'd6,
   parameter logic [3:0]  OP_STORE = 4'h4,
   parameter logic [3:0]  OP_LOAD  = 4'h5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [AW-1:0]  start_addr,
   input  logic           wake_req,
   output logic           busy,
   output logic           done,
   output logic           irq,
   output logic [3:0]     err,
   output logic           wake_stat,
   output logic           mem_req,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic [3:0]     mem_be,
   output logic [31:0]    mem_wdata,
   input  logic           mem_ack,
   input  logic [31:0]    mem_rdata,
   input  logic           mem_rdonly
);

   localparam int DW         = 32;
   localparam int NB         = DW / 8;
   localparam int DESC_WORDS = 4;
   localparam int IDXW       = $clog2(DESC_WORDS);
   localparam logic [3:0] OFS_ARG = 4'h8;
   localparam logic [3:0] OFS_RES = 4'hC;

   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("quad_desc_engine: AW must lie in 8..32");
   end
   if (OP_STORE == OP_LOAD) begin : g_bad_ops
      $error("quad_desc_engine: store and load opcodes must differ");
   end

   qd_state_e        state;
   logic [AW-1:0]    desc_base;
   logic [IDXW-1:0]  widx;
   logic             desc_ro;
   logic [ERR_W-1:0] err_q;
   logic [DW-1:0]    ld_q;
   logic             wake_q;

   logic [DESC_WORDS*DW-1:0] words;
   logic                     cap_en;

   assign cap_en = (state == ST_FETCH) && mem_ack;

   qd_desc_regs #(.DW(DW), .WORDS(DESC_WORDS)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_idx  (widx),
      .cap_data (mem_rdata),
      .words_o  (words)
   );

   logic unused_bits;
   assign unused_bits = ^{words[3*DW +: DW], start_addr[3:0]};

   logic           op_store, op_load, op_bad, misalign, key_bad, irq_en;
   logic [2:0]     size_1h;
   logic [AW-1:0]  tgt_al;
   logic [15:0]    req_cnt;

   qd_decode #(
      .AW(AW), .KEY_OK(KEY_OK), .OP_STORE(OP_STORE), .OP_LOAD(OP_LOAD)
   ) u_dec (
      .ctl_word (words[0 +: DW]),
      .tgt_word (words[DW +: DW]),
      .op_store (op_store),
      .op_load  (op_load),
      .op_bad   (op_bad),
      .size_1h  (size_1h),
      .tgt_al   (tgt_al),
      .misalign (misalign),
      .key_bad  (key_bad),
      .irq_en   (irq_en),
      .req_cnt  (req_cnt)
   );

   logic [NB-1:0] xfer_be;
   logic [DW-1:0] xfer_wdata;
   logic [DW-1:0] ld_val;

   qd_lanes #(.DW(DW)) u_lanes (
      .size_1h (size_1h),
      .lane    (tgt_al[1:0]),
      .st_val  (words[2*DW +: DW]),
      .rd_word (mem_rdata),
      .be_o    (xfer_be),
      .wdata_o (xfer_wdata),
      .ld_val  (ld_val)
   );

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_be    = '0;
      mem_wdata = '0;
      unique case (state)
         ST_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = {desc_base[AW-1:4], widx, 2'b00};
            mem_be   = '1;
         end
         ST_XFER: begin
            mem_req   = 1'b1;
            mem_we    = op_store;
            mem_addr  = tgt_al;
            mem_be    = xfer_be;
            mem_wdata = op_store ? xfer_wdata : '0;
         end
         ST_WB_ARG: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {desc_base[AW-1:4], OFS_ARG};
            mem_be    = '1;
            mem_wdata = ld_q;
         end
         ST_WB_RES: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {desc_base[AW-1:4], OFS_RES};
            mem_be    = 4'b0011;
            mem_wdata = {16'h0000, req_cnt};
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         desc_base <= '0;
         widx      <= '0;
         desc_ro   <= 1'b0;
         err_q     <= '0;
         ld_q      <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  desc_base <= {start_addr[AW-1:4], 4'h0};
                  widx      <= '0;
                  desc_ro   <= 1'b0;
                  err_q     <= '0;
                  state     <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  desc_ro <= desc_ro | mem_rdonly;
                  if (widx == IDXW'(DESC_WORDS - 1))
                     state <= ST_DECODE;
                  else
                     widx <= widx + 1'b1;
               end
            end
            ST_DECODE: begin
               err_q[ERR_KEY]   <= key_bad && !op_bad;
               err_q[ERR_ALIGN] <= misalign && !op_bad;
               err_q[ERR_DPROT] <= op_load && desc_ro;
               err_q[ERR_OP]    <= op_bad;
               state            <= op_bad ? ST_DONE : ST_XFER;
            end
            ST_XFER: begin
               if (mem_ack) begin
                  if (op_load)
                     ld_q <= ld_val;
                  if (desc_ro)
                     state <= ST_DONE;
                  else if (op_load)
                     state <= ST_WB_ARG;
                  else
                     state <= ST_WB_RES;
               end
            end
            ST_WB_ARG: begin
               if (mem_ack)
                  state <= ST_WB_RES;
            end
            ST_WB_RES: begin
               if (mem_ack)
                  state <= ST_DONE;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         wake_q <= 1'b0;
      else if (state == ST_IDLE && start)
         wake_q <= 1'b0;
      else if (wake_req)
         wake_q <= 1'b1;
   end

   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_DONE);
   assign irq       = done && irq_en;
   assign err       = err_q;
   assign wake_stat = wake_q;

endmodule

// File: rtl/quad_desc_engine_chk.sv
module quad_desc_engine_chk #(
   parameter int AW = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           busy,
   input logic           done,
   input logic           irq,
   input logic [3:0]     err,
   input logic           wake_stat,
   input logic           mem_req,
   input logic           mem_we,
   input logic [AW-1:0]  mem_addr,
   input logic [3:0]     mem_be,
   input logic [31:0]    mem_wdata,
   input logic           mem_ack
);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req)
      else $error("idle engine issued a memory request");

   p_wake_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !wake_stat)
      else $error("wake status still set after fetch began");

   p_write_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |->
         ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4))
      else $error("write with illegal byte-enable pattern");

   p_irq_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done)
      else $error("interrupt outside completion cycle");

   p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy))
      else $error("completion not a single cycle followed by idle");

   p_err_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(err))
      else $error("error bits changed while idle");

   p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=>
         (mem_req && $stable(mem_we) && $stable(mem_addr) &&
          $stable(mem_be) && $stable(mem_wdata)))
      else $error("request changed before acknowledge");

endmodule

bind quad_desc_engine quad_desc_engine_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .irq       (irq),
   .err       (err),
   .wake_stat (wake_stat),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_be    (mem_be),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack)
);

// File: tb/quad_desc_engine_test.sv
module quad_desc_engine_test;

   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic          wake_req = 1'b0;
   logic          busy, done, irq, wake_stat;
   logic [3:0]    err;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [3:0]    mem_be;
   logic [31:0]   mem_wdata;
   logic          mem_ack;
   logic [31:0]   mem_rdata;
   logic          mem_rdonly;

   always #2 clk = ~clk;

   quad_desc_engine #(.AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .wake_req(wake_req), .busy(busy), .done(done), .irq(irq), .err(err),
      .wake_stat(wake_stat), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_rdonly(mem_rdonly)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // ---------------- memory model: words 32..63 are read-only ----------------
   logic [31:0] mem [0:63];
   logic        pl_we = 1'b0;
   logic [5:0]  pl_idx = '0;
   logic [31:0] pl_data = '0;
   logic [1:0]  wait_cnt;
   logic [1:0]  lat_sel;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack    <= 1'b0;
         mem_rdata  <= '0;
         mem_rdonly <= 1'b0;
         wait_cnt   <= '0;
         lat_sel    <= '0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req) begin
         if (wait_cnt == 0) begin
            mem_ack    <= 1'b1;
            mem_rdata  <= mem[mem_addr[7:2]];
            mem_rdonly <= mem_addr[7];
            if (mem_we && !mem_addr[7]) begin
               for (int b = 0; b < 4; b++)
                  if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end
            lat_sel  <= lat_sel + 1'b1;
            wait_cnt <= (lat_sel == 2'd3) ? 2'd2 : {1'b0, lat_sel[0]};
         end else begin
            wait_cnt <= wait_cnt - 1'b1;
         end
      end
      if (pl_we) mem[pl_idx] <= pl_data;
   end

   task automatic put_word(input int idx, input logic [31:0] data);
      @(negedge clk);
      pl_we = 1'b1; pl_idx = idx[5:0]; pl_data = data;
      @(negedge clk);
      pl_we = 1'b0;
   endtask

   // ---------------- scoreboard ----------------
   typedef struct {
      bit          we;
      logic [31:0] addr;
      logic [3:0]  be;
      logic [31:0] data;
      string       tag;
   } bus_item_t;

   bus_item_t exp_q[$];

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      logic [31:0] m;
      for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
      return m;
   endfunction

   always @(negedge clk) begin
      if (rst_n && mem_req && mem_ack) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2/R10/R11", "unexpected bus access at", mem_addr, 32'hxxxxxxxx);
         end else begin
            bus_item_t e;
            e = exp_q.pop_front();
            chk(mem_we == e.we && mem_addr == e.addr && mem_be == e.be, e.tag,
                "access {we,be,addr}", {mem_we, 3'b0, mem_be, mem_addr[23:0]},
                {e.we, 3'b0, e.be, e.addr[23:0]});
            if (e.we)
               chk((mem_wdata & lane_mask(e.be)) == (e.data & lane_mask(e.be)), e.tag,
                   "write data", mem_wdata & lane_mask(e.be), e.data & lane_mask(e.be));
         end
      end
   end

   function automatic bus_item_t mk(input bit we, input logic [31:0] addr,
                                    input logic [3:0] be, input logic [31:0] data,
                                    input string tag);
      bus_item_t e;
      e.we = we; e.addr = addr; e.be = be; e.data = data; e.tag = tag;
      return e;
   endfunction

   // ---------------- driver ----------------
   task automatic run_cmd(input int base, input int addr_low, input logic [15:0] req,
                          input logic [3:0] op, input logic [7:0] key,
                          input logic [1:0] isel, input logic [31:0] tgt,
                          input logic [31:0] arg, input bit poke, input string tag);
      int          size;
      logic [31:0] al, ld_exp, old_tgt, mask, wd;
      logic [3:0]  be, exp_err;
      bit          ro, is_st, is_ld, seen_irq;
      int          cyc;
      ro    = (base >= 'h80);
      is_st = (op == 4'h4);
      is_ld = (op == 4'h5);
      size  = (req == 16'd4) ? 4 : (req == 16'd2) ? 2 : 1;
      al    = tgt & ~(size - 1);
      be    = (size == 4) ? 4'hF : (size == 2) ? (4'b0011 << al[1:0]) : (4'b0001 << al[1:0]);
      wd    = (size == 4) ? arg : (size == 2) ? {2{arg[15:0]}} : {4{arg[7:0]}};

      put_word(base/4 + 0, {op, isel, 2'b00, key, req});
      put_word(base/4 + 1, tgt);
      put_word(base/4 + 2, arg);
      put_word(base/4 + 3, 32'hC0DE_0000);

      old_tgt = mem[al[7:2]];
      ld_exp  = (old_tgt >> (8 * al[1:0])) & ((size == 4) ? 32'hFFFF_FFFF :
                                               (size == 2) ? 32'h0000_FFFF : 32'h0000_00FF);
      exp_err = 4'b0000;
      if (!is_st && !is_ld) exp_err[3] = 1'b1;
      else begin
         if (key[2:0] != 3'b110) exp_err[0] = 1'b1;
         if ((tgt & (size - 1)) != 0) exp_err[1] = 1'b1;
         if (is_ld && ro) exp_err[2] = 1'b1;
      end

      for (int w = 0; w < 4; w++)
         exp_q.push_back(mk(1'b0, base + 4*w, 4'hF, 32'h0, {tag, " R2 fetch"}));
      if (is_st || is_ld) begin
         exp_q.push_back(mk(is_st, al, be, wd, {tag, is_st ? " R6 store" : " R7 load read"}));
         if (!ro) begin
            if (is_ld) exp_q.push_back(mk(1'b1, base + 8, 4'hF, ld_exp, {tag, " R7 arg writeback"}));
            exp_q.push_back(mk(1'b1, base + 12, 4'b0011, {16'h0, req}, {tag, " R9 residual"}));
         end
      end

      @(negedge clk);
      start = 1'b1; start_addr = base + addr_low;
      @(negedge clk);
      start = 1'b0;
      seen_irq = 1'b0;
      cyc = 0;
      while (!done) begin
         cyc++;
         start      = poke && (cyc == 3);
         start_addr = 32'h30;
         @(negedge clk);
      end
      start = 1'b0;
      seen_irq = irq;
      chk(err == exp_err, tag, "R5/R8/R10/R11 error bits", {28'h0, err}, {28'h0, exp_err});
      chk(seen_irq == (isel != 2'b00), tag, "R12 irq at done", {31'h0, seen_irq},
          {31'h0, isel != 2'b00});
      @(negedge clk);
      chk(!done && !busy, tag, "R13 done pulse then idle", {30'h0, done, busy}, 32'h0);
      chk(exp_q.size() == 0, tag, "R10/R11 pending expected accesses", exp_q.size(), 0);
      exp_q.delete();
      if (is_st) begin
         mask = lane_mask(be);
         chk(mem[al[7:2]] == ((old_tgt & ~mask) | (wd & mask)), tag, "R6 target word",
             mem[al[7:2]], (old_tgt & ~mask) | (wd & mask));
      end
      if (is_ld && !ro)
         chk(mem[base/4 + 2] == ld_exp, tag, "R7 zero-extended argument",
             mem[base/4 + 2], ld_exp);
      if ((is_st || is_ld) && !ro)
         chk(mem[base/4 + 3] == {16'hC0DE, req}, tag, "R9 residual field",
             mem[base/4 + 3], {16'hC0DE, req});
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      for (int i = 0; i < 64; i++) put_word(i, 32'h1111_1111 * (i % 15));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !irq && !mem_req && !wake_stat && err == 4'h0, "R1",
          "reset state {busy,done,irq,req,wake,err}",
          {24'h0, busy, done, irq, mem_req, err}, 32'h0);

      // R3: wake set then cleared by fetch
      wake_req = 1'b1;
      @(negedge clk);
      wake_req = 1'b0;
      @(negedge clk);
      chk(wake_stat == 1'b1, "R3", "wake set", {31'h0, wake_stat}, 32'h1);

      // R6 word store, key byte with extra high bits, no irq
      run_cmd('h00, 0, 16'd4, 4'h4, 8'h0E, 2'b00, 32'h40, 32'hA1B2_C3D4, 1'b0, "R6_word");
      chk(wake_stat == 1'b0, "R3", "wake cleared after fetch", {31'h0, wake_stat}, 32'h0);
      // R4/R6 halfword store to upper lanes, irq
      run_cmd('h10, 0, 16'd2, 4'h4, 8'h06, 2'b11, 32'h46, 32'h1234_BEEF, 1'b0, "R6_half");
      // byte store to lane 3
      run_cmd('h20, 0, 16'd1, 4'h4, 8'h06, 2'b01, 32'h4B, 32'h0000_005A, 1'b0, "R6_byte");
      // R5 misaligned word store; R2 start address low bits ignored
      run_cmd('h30, 7, 16'd4, 4'h4, 8'h06, 2'b00, 32'h52, 32'hCAFE_F00D, 1'b0, "R5_store");
      // R7 word load
      run_cmd('h00, 0, 16'd4, 4'h5, 8'h06, 2'b10, 32'h40, 32'h0, 1'b0, "R7_word");
      // R4 count 7 -> byte load, lane 3
      run_cmd('h10, 0, 16'd7, 4'h5, 8'h06, 2'b00, 32'h4B, 32'hFFFF_FFFF, 1'b0, "R4_byte");
      // R8 bad key still executes; R2 start while busy ignored
      run_cmd('h20, 0, 16'd2, 4'h5, 8'h05, 2'b00, 32'h46, 32'h0, 1'b1, "R8_key");
      // R5 misaligned halfword load
      run_cmd('h30, 0, 16'd2, 4'h5, 8'h06, 2'b00, 32'h45, 32'h0, 1'b0, "R5_load");
      // R4 count 3 -> byte store
      run_cmd('h00, 0, 16'd3, 4'h4, 8'h06, 2'b00, 32'h59, 32'h0000_0077, 1'b0, "R4_cnt3");
      // R10 read-only descriptor: load flagged, no writebacks
      run_cmd('h80, 0, 16'd4, 4'h5, 8'h06, 2'b01, 32'h40, 32'h0, 1'b0, "R10_load");
      // R10 read-only descriptor: store still writes target
      run_cmd('h90, 0, 16'd4, 4'h4, 8'h06, 2'b00, 32'h5C, 32'h0BAD_CAFE, 1'b0, "R10_store");
      // R11 unknown opcode
      run_cmd('h10, 0, 16'd4, 4'h2, 8'h00, 2'b11, 32'h40, 32'h0, 1'b0, "R11_op");

      // R13 error bits held while idle
      repeat (4) @(negedge clk);
      chk(err == 4'b1000, "R13", "error bits held while idle", {28'h0, err}, 32'h8);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule